// File: doc/BRIEF.md
# Synchronous Shutter Exposure Sequencer

This block sequences a global-shutter exposure for an image sensor core that integrates on a single slope. All of its phase logic advances only on a granulated tick. The tick is a clock-enable pulse produced once every `gran_div` system clocks. A start strobe opens the sequence with a fixed reset phase, in which the core is reset and integration begins. An integration timer then counts granulated ticks up to a programmed limit and marks the end with a timeout pulse. A stop strobe then runs a short read-preparation phase that leaves the core readable.

Start and stop are separate inputs. The timeout output may be looped back externally onto the stop input. If both strobes are high at a tick, the sequencer is suspended: nothing moves at that tick. While a sequence runs, a busy output is high and any new start is ignored.

Top module: `shutter_seq`

## Requirements
- R1: A granulated tick occurs once every `gran_div` system clocks. A `gran_div` of 0 behaves as 1. Every phase duration below is a whole number of ticks, so it lasts a multiple of `gran_div` system clocks.
- R2: When idle, a tick that sees `start_req`=1 and `stop_req`=0 raises `core_rst` and `busy`. `core_rst` then stays high for exactly 4 ticks.
- R3: After the reset phase, `integ` is high. The timer advances only on ticks where `start_req`=0. `timeout` rises at tick number `int_time`+1+k after `core_rst` falls, where k is the number of ticks at which start was still high.
- R4: `timeout` is high for exactly one tick period, and `integ` is high throughout that period.
- R5: An `int_time` of 0 gives the timeout at the first counted tick.
- R6: During integration, a tick with `stop_req`=1 and `start_req`=0 ends the exposure. This holds with or without a prior timeout. `rd_prep` is then high for exactly 2 ticks, after which the block is idle.
- R7: A tick with both `start_req` and `stop_req` high changes no output or internal phase. Each such tick delays the timeout by one tick.
- R8: `busy` is high from the rise of `core_rst` until `rd_prep` falls. A start seen while busy, including during read preparation, starts no new sequence.
- R9: At most one of `core_rst`, `integ` and `rd_prep` is high at a time. Outputs change only at tick edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gran_div | input | DIVW | Granularity: system clocks per tick (0 acts as 1) |
| int_time | input | CNTW | Integration limit, in ticks minus one |
| start_req | input | 1 | Start strobe, changed on the falling clock edge |
| stop_req | input | 1 | Stop strobe, changed on the falling clock edge |
| core_rst | output | 1 | Core reset / integration-start phase |
| integ | output | 1 | Core integrating |
| rd_prep | output | 1 | Read-preparation phase |
| timeout | output | 1 | One-tick pulse when the timer reaches `int_time` |
| busy | output | 1 | Sequence in progress |

## Verification
Granularities 1 to 3 are swept against integration limits 0 to 3, with timeout looped back to stop. This separates the tick divider from the timer limit, because every measured width must scale by N while only the delay to timeout tracks the limit. Further runs do four things: hold start past the reset phase, hold both strobes together, stop early before timeout, and pulse start during read preparation. Each of these isolates the pausing of the count, suspension, early exit, and the ignoring of a start while busy. A zero granularity run confirms the divide-by-one fallback.

// File: rtl/shutter_seq.sv
module shutter_seq #(
  parameter int DIVW = 8,
  parameter int CNTW = 16,
  parameter int RSTN = 4,
  parameter int RDN  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DIVW-1:0] gran_div,
  input  logic [CNTW-1:0] int_time,
  input  logic            start_req,
  input  logic            stop_req,
  output logic            core_rst,
  output logic            integ,
  output logic            rd_prep,
  output logic            timeout,
  output logic            busy
);
  localparam int PW = $clog2(RSTN + RDN) + 1;

  typedef enum logic [2:0] {S_IDLE, S_RST, S_INT, S_EXPO, S_RP} st_t;

  st_t             st;
  logic [DIVW-1:0] div_cnt, lim;
  logic [PW-1:0]   pc;
  logic [CNTW-1:0] icnt;
  logic            to_q;
  logic            tick, adv;

  assign lim  = (gran_div == '0) ? '0 : gran_div - 1'b1;
  assign tick = div_cnt >= lim;
  assign adv  = tick & ~(start_req & stop_req);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     div_cnt <= '0;
    else if (tick)  div_cnt <= '0;
    else            div_cnt <= div_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      pc   <= '0;
      icnt <= '0;
      to_q <= 1'b0;
    end else if (adv) begin
      case (st)
        S_IDLE:
          if (start_req) begin
            st <= S_RST;
            pc <= '0;
          end
        S_RST:
          if (pc == PW'(RSTN - 1)) begin
            st   <= S_INT;
            icnt <= '0;
            pc   <= '0;
          end else begin
            pc <= pc + 1'b1;
          end
        S_INT:
          if (stop_req) begin
            st <= S_RP;
            pc <= '0;
          end else if (!start_req) begin
            if (icnt == int_time) begin
              to_q <= 1'b1;
              st   <= S_EXPO;
            end else begin
              icnt <= icnt + 1'b1;
            end
          end
        S_EXPO: begin
          to_q <= 1'b0;
          if (stop_req) begin
            st <= S_RP;
            pc <= '0;
          end
        end
        S_RP:
          if (pc == PW'(RDN - 1)) st <= S_IDLE;
          else                    pc <= pc + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign core_rst = st == S_RST;
  assign integ    = (st == S_INT) || (st == S_EXPO);
  assign rd_prep  = st == S_RP;
  assign timeout  = to_q;
  assign busy     = st != S_IDLE;
endmodule

module shutter_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic start_req,
  input logic stop_req,
  input logic core_rst,
  input logic integ,
  input logic rd_prep,
  input logic timeout,
  input logic busy
);
  a_r9_phase_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({core_rst, integ, rd_prep}));

  a_r9_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable({core_rst, integ, rd_prep, timeout, busy}));

  a_r7_suspend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && start_req && stop_req) |=> $stable({core_rst, integ, rd_prep, timeout, busy}));

  a_r4_timeout_in_integ: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> integ);

  a_r8_busy_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rst || integ || rd_prep) |-> busy);

  a_r6_end_after_rp: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(rd_prep));

  a_r2_rst_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_rst) |-> $past(start_req && !stop_req && !busy));
endmodule

bind shutter_seq shutter_seq_chk i_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .start_req(start_req), .stop_req(stop_req),
  .core_rst(core_rst), .integ(integ), .rd_prep(rd_prep), .timeout(timeout), .busy(busy)
);

// File: tb/test_shutter_seq.sv
module test_shutter_seq;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  gran_div = 8'd1;
  logic [15:0] int_time = '0;
  logic        start_req = 0, stop_req = 0;
  logic        core_rst, integ, rd_prep, timeout, busy;
  int          n_chk = 0, n_err = 0;
  bit          done = 0;

  shutter_seq i_shutter_seq (
    .clk(clk), .rst_n(rst_n), .gran_div(gran_div), .int_time(int_time),
    .start_req(start_req), .stop_req(stop_req), .core_rst(core_rst),
    .integ(integ), .rd_prep(rd_prep), .timeout(timeout), .busy(busy));

  always #4 clk = ~clk;

  task automatic chk_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // k: extra ticks start is held; m: suspended ticks; e: early stop negedge
  task automatic run_exp(input int n, input int t, input int k, input int m, input int e);
    int w, j, nn, bad;
    nn = (n == 0) ? 1 : n;
    gran_div = 8'(n);
    int_time = 16'(t);
    @(negedge clk);
    start_req = 1;
    w = 0;
    while (!core_rst && w < 1000) begin @(negedge clk); w++; end
    chk_eq("R8 busy with core reset", int'(busy), 1);
    if (k == 0 && m == 0) start_req = 0;
    w = 0;
    while (core_rst && w < 1000) begin w++; @(negedge clk); end
    chk_eq("R2 R1 reset phase clocks", w, 4 * nn);
    chk_eq("R3 integ after reset phase", int'(integ), 1);
    j = 1; bad = 0;
    while (!timeout && !rd_prep && j < 2000) begin
      if (k > 0) start_req = (j <= k * nn);
      if (m > 0) begin
        if (j > 1 && (rd_prep || core_rst || !integ)) bad = 1;
        start_req = (j <= m * nn);
        stop_req  = (j <= m * nn);
      end
      if (e > 0 && j == e) stop_req = 1;
      @(negedge clk); j++;
    end
    if (m > 0) chk_eq("R7 no phase change while suspended", bad, 0);
    if (e > 0) begin
      chk_eq("R6 early stop without timeout", int'(timeout), 0);
      chk_eq("R6 early stop entry clocks", j - 1, ((e + nn - 1) / nn) * nn);
    end else begin
      chk_eq("R3 R5 clocks to timeout", j - 1, nn * (t + 1 + k + m));
      stop_req = 1;
      w = 0; bad = 0;
      while (timeout && w < 1000) begin
        if (!integ) bad = 1;
        w++; @(negedge clk);
      end
      chk_eq("R4 timeout width clocks", w, nn);
      chk_eq("R4 integ during timeout", bad, 0);
      chk_eq("R6 feedback stop enters read prep", int'(rd_prep), 1);
    end
    stop_req = 0;
    w = 0;
    while (rd_prep && w < 1000) begin
      if (w == 1) start_req = 1;
      if (w == 1 + nn) start_req = 0;
      w++; @(negedge clk);
    end
    start_req = 0;
    chk_eq("R6 read prep width clocks", w, 2 * nn);
    chk_eq("R8 busy low after read prep", int'(busy), 0);
    bad = 0;
    for (int i = 0; i < 3 * nn + 2; i++) begin
      if (core_rst || busy) bad = 1;
      @(negedge clk);
    end
    chk_eq("R8 start during read prep ignored", bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_eq("R8 reset busy", int'(busy), 0);
    chk_eq("R9 reset phases", int'({core_rst, integ, rd_prep, timeout}), 0);
    rst_n = 1;
    for (int n = 1; n <= 3; n++)
      for (int t = 0; t <= 3; t++)
        run_exp(n, t, 0, 0, 0);
    run_exp(0, 1, 0, 0, 0);   // R1 zero granularity
    run_exp(2, 1, 2, 0, 0);   // R3 start held
    run_exp(3, 0, 1, 0, 0);   // R3 R5
    run_exp(2, 2, 0, 2, 0);   // R7
    run_exp(1, 0, 0, 3, 0);   // R7
    run_exp(2, 3, 0, 0, 3);   // R6 early
    run_exp(1, 3, 0, 0, 2);   // R6 early
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule